// File: doc/BRIEF.md
# Per-CPU Interrupt Mailbox

The block holds one mailbox slot for each CPU. An external bus offers interrupt messages, and each message names a target CPU and carries a 5-bit source ID and two 64-bit data words. When the target slot is free, the block takes the message in that cycle. It stores the source and both words, and it marks the slot busy. On the next cycle it posts a shared, software-programmable 6-bit vector to that CPU. When the slot is already busy, the block refuses the message by holding `msg_ready_o` low, and the sender retries later.

Software reaches the slots through a register port. Reads are combinational. Each slot has an indexed address, and three alias addresses pick the slot of the CPU that issues the request (`reg_cpu_i`). A handler reads the two data words and the status word. It then writes the status word with bit 5 clear, which frees the slot for the next message.

Top module: `irq_mailbox`

## Requirements
- R1: After reset, every slot is free with source and data zero, the vector register reads zero, and `post_valid_o` is low.
- R2: A message to a free slot of a CPU below `NUM_CPUS` drives `msg_ready_o` high in the same cycle. From the next cycle the slot is busy and holds that message's source and data words.
- R3: A message to a busy slot drives `msg_ready_o` low, leaves that slot's contents unchanged and posts nothing.
- R4: The cycle after an accepted message, `post_valid_o` is high for exactly one cycle. In that cycle `post_cpu_o` is the target CPU, and `post_vec_o` is the vector register value at the time of acceptance.
- R5: A write to address 0x318 loads the vector register from write-data bits 5:0. A read of 0x318 returns it zero-extended.
- R6: Reading status at 0x200 + 8*n returns busy in bit 5 and the source ID in bits 4:0, with all other bits zero.
- R7: Data word 0 of slot n reads at 0x000 + 8*n, and data word 1 reads at 0x100 + 8*n.
- R8: Addresses 0x300 (data word 0), 0x308 (data word 1) and 0x310 (status) access the slot selected by `reg_cpu_i`.
- R9: A write to a status address loads busy from write-data bit 5. The stored source and the other write bits have no effect.
- R10: If a status write that clears busy and a message target the same slot in one cycle, the clear is applied first and the message is accepted.
- R11: Messages to CPU IDs of `NUM_CPUS` or more are refused. Register accesses to slots at or above `NUM_CPUS`, or to unmapped addresses, read as zero and have no effect. Address bits 2:0 are ignored.
- R12: Writes to data-word addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_valid_i | input | 1 | Incoming message valid |
| msg_cpu_i | input | 5 | Target CPU ID |
| msg_src_i | input | 5 | Source ID of the message |
| msg_d0_i | input | 64 | Message data word 0 |
| msg_d1_i | input | 64 | Message data word 1 |
| msg_ready_o | output | 1 | Message accepted this cycle |
| reg_addr_i | input | 12 | Register byte address |
| reg_cpu_i | input | 5 | ID of the CPU issuing the register access |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data (combinational) |
| post_valid_o | output | 1 | Interrupt post strobe |
| post_cpu_o | output | 5 | CPU receiving the post |
| post_vec_o | output | 6 | Vector posted |

## Verification
Directed cases put a message on a free slot, a busy slot and an out-of-range CPU. Together they separate acceptance from backpressure and from range checking. A status clear issued in the same cycle as a message for that slot tells clear-first ordering apart from message-first ordering. Alias reads and writes from different requesting CPUs, set against indexed accesses, show whether the alias follows `reg_cpu_i` and not an address field. Constrained-random runs mix messages, status writes, vector writes, data-word writes and reads across in-range and out-of-range slots, and compare every result with a bench model.

// File: rtl/irq_mbx_pkg.sv
package irq_mbx_pkg;
  localparam int CPU_ID_W = 5;
  localparam int SRC_W    = 5;
  localparam int DATA_W   = 64;
  localparam int ADDR_W   = 12;
  localparam int VEC_W    = 6;
  localparam int BUSY_BIT = 5;
  localparam int MAX_CPUS = 1 << CPU_ID_W;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_D0,
    ACC_D1,
    ACC_STAT,
    ACC_VEC
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e             kind;
    logic [CPU_ID_W-1:0]   idx;
    logic                  hit;
  } acc_sel_t;
endpackage

// File: rtl/irq_mbx_dec.sv
module irq_mbx_dec
  import irq_mbx_pkg::*;
#(
  parameter int NUM_CPUS = 8
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [CPU_ID_W-1:0] req_cpu_i,
  output acc_sel_t            sel_o
);
  localparam int REG_W = ADDR_W - 8;

  logic [REG_W-1:0]    region;
  logic [4:0]          word;
  logic [2:0]          unused_low;

  assign region     = addr_i[ADDR_W-1:8];
  assign word       = addr_i[7:3];
  assign unused_low = addr_i[2:0];

  always_comb begin
    sel_o.kind = ACC_NONE;
    sel_o.idx  = word[CPU_ID_W-1:0];
    unique case (region)
      REG_W'(0): sel_o.kind = ACC_D0;
      REG_W'(1): sel_o.kind = ACC_D1;
      REG_W'(2): sel_o.kind = ACC_STAT;
      REG_W'(3): begin
        sel_o.idx = req_cpu_i;
        unique case (word)
          5'd0:    sel_o.kind = ACC_D0;
          5'd1:    sel_o.kind = ACC_D1;
          5'd2:    sel_o.kind = ACC_STAT;
          5'd3:    sel_o.kind = ACC_VEC;
          default: sel_o.kind = ACC_NONE;
        endcase
      end
      default: sel_o.kind = ACC_NONE;
    endcase
    sel_o.hit = (sel_o.kind == ACC_VEC) ||
                ((sel_o.kind != ACC_NONE) && (int'(sel_o.idx) < NUM_CPUS));
  end
endmodule

// File: rtl/irq_mbx_slot.sv
module irq_mbx_slot
  import irq_mbx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [SRC_W-1:0]  src_i,
  input  logic [DATA_W-1:0] d0_i,
  input  logic [DATA_W-1:0] d1_i,
  input  logic              busy_we_i,
  input  logic              busy_wd_i,
  output logic              busy_o,
  output logic [SRC_W-1:0]  src_o,
  output logic [DATA_W-1:0] d0_o,
  output logic [DATA_W-1:0] d1_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      src_o  <= '0;
      d0_o   <= '0;
      d1_o   <= '0;
    end else if (take_i) begin
      // a take implies any same-cycle clear has already been honoured
      busy_o <= 1'b1;
      src_o  <= src_i;
      d0_o   <= d0_i;
      d1_o   <= d1_i;
    end else if (busy_we_i) begin
      busy_o <= busy_wd_i;
    end
  end
endmodule

// File: rtl/irq_mbx_post.sv
module irq_mbx_post
  import irq_mbx_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                vec_we_i,
  input  logic [VEC_W-1:0]    vec_wd_i,
  input  logic                take_i,
  input  logic [CPU_ID_W-1:0] take_cpu_i,
  output logic [VEC_W-1:0]    vec_o,
  output logic                post_valid_o,
  output logic [CPU_ID_W-1:0] post_cpu_o,
  output logic [VEC_W-1:0]    post_vec_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o <= '0;
    end else if (vec_we_i) begin
      vec_o <= vec_wd_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      post_valid_o <= 1'b0;
      post_cpu_o   <= '0;
      post_vec_o   <= '0;
    end else begin
      post_valid_o <= take_i;
      if (take_i) begin
        post_cpu_o <= take_cpu_i;
        post_vec_o <= vec_o;
      end
    end
  end
endmodule

// File: rtl/irq_mailbox.sv
module irq_mailbox
  import irq_mbx_pkg::*;
#(
  parameter int NUM_CPUS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                msg_valid_i,
  input  logic [4:0]          msg_cpu_i,
  input  logic [4:0]          msg_src_i,
  input  logic [63:0]         msg_d0_i,
  input  logic [63:0]         msg_d1_i,
  output logic                msg_ready_o,
  input  logic [11:0]         reg_addr_i,
  input  logic [4:0]          reg_cpu_i,
  input  logic                reg_we_i,
  input  logic [63:0]         reg_wdata_i,
  output logic [63:0]         reg_rdata_o,
  output logic                post_valid_o,
  output logic [4:0]          post_cpu_o,
  output logic [5:0]          post_vec_o
);
  acc_sel_t               sel;
  logic [NUM_CPUS-1:0]    busy_w;
  logic [NUM_CPUS-1:0]    take_w;
  logic [NUM_CPUS-1:0]    busy_we_w;
  logic [MAX_CPUS-1:0]    busy_pad;
  logic [MAX_CPUS-1:0]    clr_pad;
  logic [SRC_W-1:0]       src_w [NUM_CPUS];
  logic [DATA_W-1:0]      d0_w  [NUM_CPUS];
  logic [DATA_W-1:0]      d1_w  [NUM_CPUS];
  logic [VEC_W-1:0]       vec_q;
  logic                   wr_stat;
  logic                   wr_vec;
  logic                   tgt_ok;
  logic                   take_any;
  logic [DATA_W-VEC_W-1:0] unused_wd;

  assign unused_wd = reg_wdata_i[DATA_W-1:VEC_W];

  irq_mbx_dec #(.NUM_CPUS(NUM_CPUS)) u_dec (
    .addr_i    (reg_addr_i),
    .req_cpu_i (reg_cpu_i),
    .sel_o     (sel)
  );

  assign wr_stat = reg_we_i && sel.hit && (sel.kind == ACC_STAT);
  assign wr_vec  = reg_we_i && (sel.kind == ACC_VEC);

  assign busy_pad = MAX_CPUS'(busy_w);
  assign clr_pad  = MAX_CPUS'(busy_we_w & {NUM_CPUS{~reg_wdata_i[BUSY_BIT]}});

  // clear-before-message: a same-cycle clear frees the slot for this message
  assign tgt_ok      = int'(msg_cpu_i) < NUM_CPUS;
  assign msg_ready_o = msg_valid_i && tgt_ok &&
                       (!busy_pad[msg_cpu_i] || clr_pad[msg_cpu_i]);
  assign take_any    = |take_w;

  for (genvar n = 0; n < NUM_CPUS; n++) begin : g_slot
    assign busy_we_w[n] = wr_stat && (int'(sel.idx) == n);
    assign take_w[n]    = msg_ready_o && (int'(msg_cpu_i) == n);

    irq_mbx_slot u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .take_i    (take_w[n]),
      .src_i     (msg_src_i),
      .d0_i      (msg_d0_i),
      .d1_i      (msg_d1_i),
      .busy_we_i (busy_we_w[n]),
      .busy_wd_i (reg_wdata_i[BUSY_BIT]),
      .busy_o    (busy_w[n]),
      .src_o     (src_w[n]),
      .d0_o      (d0_w[n]),
      .d1_o      (d1_w[n])
    );
  end

  irq_mbx_post u_post (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .vec_we_i     (wr_vec),
    .vec_wd_i     (reg_wdata_i[VEC_W-1:0]),
    .take_i       (take_any),
    .take_cpu_i   (msg_cpu_i),
    .vec_o        (vec_q),
    .post_valid_o (post_valid_o),
    .post_cpu_o   (post_cpu_o),
    .post_vec_o   (post_vec_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (sel.kind == ACC_VEC) begin
      reg_rdata_o = DATA_W'(vec_q);
    end
    for (int n = 0; n < NUM_CPUS; n++) begin
      if (sel.hit && (int'(sel.idx) == n)) begin
        unique case (sel.kind)
          ACC_D0:   reg_rdata_o = d0_w[n];
          ACC_D1:   reg_rdata_o = d1_w[n];
          ACC_STAT: reg_rdata_o = DATA_W'({busy_w[n], src_w[n]});
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_mbx_chk.sv
module irq_mbx_chk
  import irq_mbx_pkg::*;
#(
  parameter int NUM_CPUS = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                msg_valid_i,
  input logic [CPU_ID_W-1:0] msg_cpu_i,
  input logic                msg_ready_i,
  input logic                post_valid_i,
  input logic [CPU_ID_W-1:0] post_cpu_i,
  input logic [MAX_CPUS-1:0] busy_i,
  input logic [MAX_CPUS-1:0] clr_i,
  input logic                vec_we_i,
  input logic [VEC_W-1:0]    vec_i
);
  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_ready_i |=> busy_i[$past(msg_cpu_i)]); // R2

  AST_BUSY_REFUSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_i && busy_i[msg_cpu_i] && !clr_i[msg_cpu_i]) |-> !msg_ready_i); // R3

  AST_POST_FOLLOWS_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_ready_i |=> (post_valid_i && post_cpu_i == $past(msg_cpu_i))); // R4

  AST_NO_SPURIOUS_POST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msg_ready_i |=> !post_valid_i); // R4

  AST_VEC_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_we_i |=> $stable(vec_i)); // R5

  AST_CLEAR_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_i && int'(msg_cpu_i) < NUM_CPUS && clr_i[msg_cpu_i]) |-> msg_ready_i); // R10

  AST_RANGE_REFUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(msg_cpu_i) >= NUM_CPUS) |-> !msg_ready_i); // R11
endmodule

bind irq_mailbox irq_mbx_chk #(.NUM_CPUS(NUM_CPUS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .msg_valid_i  (msg_valid_i),
  .msg_cpu_i    (msg_cpu_i),
  .msg_ready_i  (msg_ready_o),
  .post_valid_i (post_valid_o),
  .post_cpu_i   (post_cpu_o),
  .busy_i       (busy_pad),
  .clr_i        (clr_pad),
  .vec_we_i     (wr_vec),
  .vec_i        (vec_q)
);

// File: tb/sim_irq_mailbox.sv
`timescale 1ns/1ps
module sim_irq_mailbox;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_valid = 1'b0;
  logic [4:0]  msg_cpu = '0;
  logic [4:0]  msg_src = '0;
  logic [63:0] msg_d0 = '0;
  logic [63:0] msg_d1 = '0;
  logic        msg_ready;
  logic [11:0] reg_addr = '0;
  logic [4:0]  reg_cpu = '0;
  logic        reg_we = 1'b0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        post_valid;
  logic [4:0]  post_cpu;
  logic [5:0]  post_vec;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic        m_busy [32];
  logic [4:0]  m_src  [32];
  logic [63:0] m_d0   [32];
  logic [63:0] m_d1   [32];
  logic [5:0]  m_vec;

  always #4 clk = ~clk;

  irq_mailbox #(.NUM_CPUS(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .msg_valid_i(msg_valid), .msg_cpu_i(msg_cpu), .msg_src_i(msg_src),
    .msg_d0_i(msg_d0), .msg_d1_i(msg_d1), .msg_ready_o(msg_ready),
    .reg_addr_i(reg_addr), .reg_cpu_i(reg_cpu), .reg_we_i(reg_we),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .post_valid_o(post_valid), .post_cpu_o(post_cpu), .post_vec_o(post_vec)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_read(input logic [11:0] a, input logic [4:0] rc);
    logic [3:0] region = a[11:8];
    logic [4:0] w      = a[7:3];
    logic [4:0] idx    = (region == 4'd3) ? rc : w;
    logic [63:0] r = '0;
    if (region == 4'd3 && w == 5'd3) return 64'(m_vec);
    if (region > 4'd3 || (region == 4'd3 && w > 5'd3)) return '0;
    if (int'(idx) >= N) return '0;
    if (region == 4'd0 || (region == 4'd3 && w == 5'd0)) r = m_d0[idx];
    else if (region == 4'd1 || (region == 4'd3 && w == 5'd1)) r = m_d1[idx];
    else r = 64'({m_busy[idx], m_src[idx]});
    return r;
  endfunction

  function automatic void model_wr(input logic [11:0] a, input logic [4:0] rc, input logic [63:0] wd);
    logic [3:0] region = a[11:8];
    logic [4:0] w      = a[7:3];
    if (region == 4'd2 && int'(w) < N) m_busy[w] = wd[5];
    if (region == 4'd3 && w == 5'd2 && int'(rc) < N) m_busy[rc] = wd[5];
    if (region == 4'd3 && w == 5'd3) m_vec = wd[5:0];
  endfunction

  task automatic do_rd(input logic [11:0] a, input logic [4:0] rc, input string tag);
    @(negedge clk);
    reg_addr = a; reg_cpu = rc; reg_we = 1'b0;
    #1;
    chk(reg_rdata === exp_read(a, rc), tag, reg_rdata, exp_read(a, rc));
  endtask

  task automatic do_wr(input logic [11:0] a, input logic [4:0] rc, input logic [63:0] wd);
    @(negedge clk);
    reg_addr = a; reg_cpu = rc; reg_wdata = wd; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    model_wr(a, rc, wd);
  endtask

  task automatic do_msg(input logic [4:0] c, input logic [4:0] s, input logic [63:0] a0,
                        input logic [63:0] a1, input string tag);
    bit acc;
    @(negedge clk);
    msg_valid = 1'b1; msg_cpu = c; msg_src = s; msg_d0 = a0; msg_d1 = a1;
    acc = (int'(c) < N) && !m_busy[c];
    #1;
    chk(msg_ready === acc, {tag, " ready"}, 64'(msg_ready), 64'(acc));
    @(negedge clk);
    msg_valid = 1'b0;
    chk(post_valid === acc, {tag, " R4 post_valid"}, 64'(post_valid), 64'(acc));
    if (acc) begin
      chk(post_cpu === c && post_vec === m_vec, {tag, " R4 post cpu/vec"},
          64'({post_cpu, post_vec}), 64'({c, m_vec}));
      m_busy[c] = 1'b1; m_src[c] = s; m_d0[c] = a0; m_d1[c] = a1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit both_acc;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 32; i++) begin
      m_busy[i] = 1'b0; m_src[i] = '0; m_d0[i] = '0; m_d1[i] = '0;
    end
    m_vec = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    chk(post_valid === 1'b0, "R1 post_valid", 64'(post_valid), 64'd0);
    for (int i = 0; i < N; i++) do_rd(12'h200 + 12'(i * 8), 5'd0, "R1 status");
    do_rd(12'h318, 5'd0, "R1 vec");

    // R5 vector, upper bits ignored
    do_wr(12'h318, 5'd0, 64'hFFFF_FFFF_FFFF_FFEA);
    do_rd(12'h318, 5'd0, "R5 vec readback");

    // R2 accept, R6/R7 readback
    do_msg(5'd3, 5'h11, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, "R2 free slot");
    do_rd(12'h218, 5'd0, "R6 status idx3");
    do_rd(12'h018, 5'd0, "R7 d0 idx3");
    do_rd(12'h118, 5'd0, "R7 d1 idx3");
    do_rd(12'h11C, 5'd0, "R11 low addr bits ignored");

    // R3 refused on busy
    do_msg(5'd3, 5'h07, 64'h1, 64'h2, "R3 busy slot");
    do_rd(12'h218, 5'd0, "R3 status kept");
    do_rd(12'h018, 5'd0, "R3 d0 kept");

    // R8 alias
    do_rd(12'h300, 5'd3, "R8 alias d0");
    do_rd(12'h308, 5'd3, "R8 alias d1");
    do_rd(12'h310, 5'd3, "R8 alias status");
    do_rd(12'h310, 5'd2, "R8 alias other cpu");

    // R12 data words read-only
    do_wr(12'h018, 5'd0, 64'hDEAD_BEEF_0000_0000);
    do_wr(12'h300, 5'd3, 64'hDEAD_BEEF_1111_1111);
    do_rd(12'h018, 5'd0, "R12 d0 unchanged");
    do_rd(12'h218, 5'd0, "R12 status unchanged");

    // R9 clear keeps source
    do_wr(12'h218, 5'd0, 64'hFFFF_FFFF_FFFF_FFDF);
    do_rd(12'h218, 5'd0, "R9 clear keeps source");
    do_wr(12'h228, 5'd0, 64'h20);
    do_rd(12'h228, 5'd0, "R9 set busy");
    do_msg(5'd5, 5'h1F, 64'h5, 64'h6, "R9 R3 set busy refuses");
    do_wr(12'h310, 5'd5, 64'h0);
    do_rd(12'h228, 5'd0, "R9 alias clear");
    do_msg(5'd5, 5'h0A, 64'hAA, 64'hBB, "R2 after clear");

    // R10 same-cycle clear and message on slot 5 (busy)
    @(negedge clk);
    reg_addr = 12'h228; reg_wdata = 64'h0; reg_we = 1'b1;
    msg_valid = 1'b1; msg_cpu = 5'd5; msg_src = 5'h13; msg_d0 = 64'hC0; msg_d1 = 64'hC1;
    #1;
    both_acc = msg_ready;
    chk(msg_ready === 1'b1, "R10 ready with clear", 64'(msg_ready), 64'd1);
    @(negedge clk);
    reg_we = 1'b0; msg_valid = 1'b0;
    chk(post_valid === 1'b1 && post_cpu === 5'd5, "R10 post", 64'({post_valid, post_cpu}), 64'({1'b1, 5'd5}));
    m_busy[5] = 1'b1; m_src[5] = 5'h13; m_d0[5] = 64'hC0; m_d1[5] = 64'hC1;
    do_rd(12'h228, 5'd0, "R10 status busy new source");
    if (!both_acc) m_busy[5] = 1'b1;

    // R11 out of range
    do_msg(5'd9, 5'h01, 64'h9, 64'h9, "R11 cpu out of range");
    do_wr(12'h248, 5'd0, 64'h20);
    do_rd(12'h248, 5'd0, "R11 status oor reads zero");
    do_rd(12'h310, 5'd12, "R11 alias oor");
    do_rd(12'h400, 5'd0, "R11 unmapped");

    // Random mix
    for (int it = 0; it < 600; it++) begin
      int op;
      logic [11:0] a;
      logic [4:0] rc;
      op = int'($urandom_range(0, 9));
      rc = 5'($urandom_range(0, 10));
      case ($urandom_range(0, 4))
        0: a = {4'd0, 5'($urandom_range(0, 10)), 3'd0};
        1: a = {4'd1, 5'($urandom_range(0, 10)), 3'd0};
        2: a = {4'd2, 5'($urandom_range(0, 10)), 3'd0};
        3: a = {4'd3, 5'($urandom_range(0, 4)), 3'd0};
        default: a = {4'($urandom_range(0, 5)), 5'($urandom_range(0, 31)), 3'($urandom)};
      endcase
      if (op < 4)
        do_msg(5'($urandom_range(0, 9)), 5'($urandom), {$urandom, $urandom},
               {$urandom, $urandom}, "R2 R3 random msg");
      else if (op < 6)
        do_wr(a, rc, {$urandom, $urandom});
      else
        do_rd(a, rc, "R6 R7 R8 random read");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule